// File: doc/BRIEF.md
# Clock-Enable Suspend Controller

This block sits in the command front end of a synchronous DRAM. On every clock edge it registers the clock-enable input. The registered value becomes the internal clock qualifier for the next cycle. While that qualifier is low, the block turns the incoming command into a no-op, and it freezes bank-activity state and the burst counter. Suspension therefore takes effect one cycle after a low enable is sampled. It ends one cycle after a high enable is sampled.

The block keeps a bitmap of banks with an open row. ACTIVATE and PRECHARGE commands that are accepted update this bitmap. While the clock is suspended, the block uses the bitmap to report one of two states:
- standby power-down, when no bank is open;
- active power-down, when at least one bank is open.

A read or write burst of fixed length is frozen by a suspended cycle, not aborted. A read holds its current beat index. A write takes no data on that cycle. The remaining beats continue once the clock runs again.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: While rst_ni is low and directly after its release: int_clk_en_o=1, suspend_o=0, bank_open_o=0, burst_busy_o=0, beat_o=0, burst_adv_o=0.
- R2: int_clk_en_o during a cycle equals the value of cke_i sampled at the rising edge that started the cycle. suspend_o is its inverse.
- R3: While int_clk_en_o=0, cmd_o reads NOP (code 0), and bank_open_o, burst_busy_o, burst_write_o and beat_o keep their values across the next edge. While int_clk_en_o=1, cmd_o equals cmd_i.
- R4: Command codes are NOP=0, ACTIVATE=1, PRECHARGE=2, READ=3 and WRITE=4; other codes do nothing. An accepted ACTIVATE sets bit bank_i of bank_open_o. An accepted PRECHARGE clears that bit, or clears every bit when all_banks_i=1.
- R5: pd_standby_o is 1 exactly when suspend_o=1 and bank_open_o=0.
- R6: pd_active_o is 1 exactly when suspend_o=1 and bank_open_o is non-zero.
- R7: An accepted READ or WRITE starts a burst on the next cycle with burst_busy_o=1 and beat_o=0. Each unsuspended burst cycle advances beat_o by one. After the cycle with beat 3, burst_busy_o returns to 0. burst_write_o is 1 for a WRITE. A new READ or WRITE restarts the burst at beat 0.
- R8: burst_adv_o is 1 exactly when burst_busy_o=1 and int_clk_en_o=1. A suspended burst cycle leaves beat_o unchanged, and the beats resume afterwards.
- R9: wr_capture_o is 1 exactly when burst_adv_o=1 and burst_write_o=1, so no write data is taken on a suspended cycle.
- R10: In the first cycle after a high cke_i is sampled again, a command is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, sampled each rising edge |
| cmd_i | input | 3 | Command code |
| bank_i | input | 2 | Addressed bank |
| all_banks_i | input | 1 | Precharge-all flag |
| int_clk_en_o | output | 1 | Internal clock qualifier for this cycle |
| cmd_o | output | 3 | Qualified command (NOP when suspended) |
| suspend_o | output | 1 | Cycle is suspended |
| pd_standby_o | output | 1 | Suspended with all banks idle |
| pd_active_o | output | 1 | Suspended with a bank open |
| bank_open_o | output | 4 | Per-bank open-row flags |
| burst_busy_o | output | 1 | Burst in progress |
| burst_write_o | output | 1 | Current burst is a write |
| beat_o | output | 2 | Current beat index |
| burst_adv_o | output | 1 | Burst advances at the next edge |
| wr_capture_o | output | 1 | Write data taken this cycle |

## Verification
cmd_o, burst_adv_o, wr_capture_o and the power-down flags are due in the same cycle as the inputs that form them. int_clk_en_o follows cke_i by one edge. bank_open_o, burst_busy_o and beat_o change one edge after the command or advance that causes them. The bench drives every cycle just after a falling edge and queues the values it predicts for that cycle. The monitor checks them 1 ns later, well before the next rising edge. Every registered effect is therefore compared in the first cycle where it must show, and never before.

// File: rtl/cke_suspend_pkg.sv
package cke_suspend_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/cke_gate.sv
module cke_gate
  import cke_suspend_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic [2:0] cmd_i,
  output logic       int_en_o,
  output logic [2:0] cmd_o
);
  logic cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  assign int_en_o = cke_q;
  assign cmd_o    = cke_q ? cmd_i : CMD_NOP;
endmodule

// File: rtl/bank_track.sv
module bank_track
  import cke_suspend_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 all_i,
  output logic [NUM_BANKS-1:0] open_o
);
  logic is_act, is_pre;
  assign is_act = (cmd_i == CMD_ACT);
  assign is_pre = (cmd_i == CMD_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     open_o[b] <= 1'b0;
      else if (is_act && hit)          open_o[b] <= 1'b1;
      else if (is_pre && (hit || all_i)) open_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_ctr.sv
module burst_ctr
  import cke_suspend_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic              int_en_i,
  output logic              busy_o,
  output logic              write_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              adv_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

  logic start;
  assign start = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  // advance only on cycles whose internal clock runs
  assign adv_o = busy_o && int_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      write_o <= 1'b0;
      beat_o  <= '0;
    end else if (start) begin
      busy_o  <= 1'b1;
      write_o <= (cmd_i == CMD_WR);
      beat_o  <= '0;
    end else if (adv_o) begin
      if (beat_o == LAST) begin
        busy_o <= 1'b0;
        beat_o <= '0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BA_W   = $clog2(NUM_BANKS),
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 all_banks_i,
  output logic                 int_clk_en_o,
  output logic [2:0]           cmd_o,
  output logic                 suspend_o,
  output logic                 pd_standby_o,
  output logic                 pd_active_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 burst_busy_o,
  output logic                 burst_write_o,
  output logic [BEAT_W-1:0]    beat_o,
  output logic                 burst_adv_o,
  output logic                 wr_capture_o
);
  logic int_en;
  logic [2:0] qcmd;

  cke_gate i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_i    (cke_i),
    .cmd_i    (cmd_i),
    .int_en_o (int_en),
    .cmd_o    (qcmd)
  );

  bank_track #(.NUM_BANKS(NUM_BANKS)) i_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (qcmd),
    .bank_i (bank_i),
    .all_i  (all_banks_i),
    .open_o (bank_open_o)
  );

  burst_ctr #(.BURST_LEN(BURST_LEN)) i_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (qcmd),
    .int_en_i (int_en),
    .busy_o   (burst_busy_o),
    .write_o  (burst_write_o),
    .beat_o   (beat_o),
    .adv_o    (burst_adv_o)
  );

  assign int_clk_en_o = int_en;
  assign cmd_o        = qcmd;
  assign suspend_o    = ~int_en;
  assign pd_standby_o = ~int_en & ~(|bank_open_o);
  assign pd_active_o  = ~int_en & (|bank_open_o);
  assign wr_capture_o = burst_adv_o & burst_write_o;
endmodule

// File: rtl/cke_suspend_chk.sv
module cke_suspend_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BEAT_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 int_clk_en_o,
  input logic [2:0]           cmd_o,
  input logic                 suspend_o,
  input logic                 pd_standby_o,
  input logic                 pd_active_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 burst_busy_o,
  input logic                 burst_write_o,
  input logic [BEAT_W-1:0]    beat_o,
  input logic                 burst_adv_o,
  input logic                 wr_capture_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    int_clk_en_o == $past(cke_i));
  assert_drop_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_en_o |-> cmd_o == 3'd0);
  assert_hold_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(suspend_o) |-> $stable(bank_open_o) && $stable(burst_busy_o) && $stable(beat_o)
                         && $stable(burst_write_o));
  assert_standby_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_standby_o |-> suspend_o && bank_open_o == '0);
  assert_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_active_o |-> suspend_o && bank_open_o != '0);
  assert_pd_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pd_standby_o, pd_active_o}));
  assert_adv_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_adv_o |-> burst_busy_o && !suspend_o);
  assert_wr_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_capture_o |-> burst_adv_o && burst_write_o);
endmodule

bind cke_suspend_ctrl cke_suspend_chk #(.NUM_BANKS(NUM_BANKS), .BEAT_W(BEAT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cke_i         (cke_i),
  .int_clk_en_o  (int_clk_en_o),
  .cmd_o         (cmd_o),
  .suspend_o     (suspend_o),
  .pd_standby_o  (pd_standby_o),
  .pd_active_o   (pd_active_o),
  .bank_open_o   (bank_open_o),
  .burst_busy_o  (burst_busy_o),
  .burst_write_o (burst_write_o),
  .beat_o        (beat_o),
  .burst_adv_o   (burst_adv_o),
  .wr_capture_o  (wr_capture_o)
);

// File: tb/test_cke_suspend_ctrl.sv
`timescale 1ns/1ps
module test_cke_suspend_ctrl;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_RD = 3'd3, C_WR = 3'd4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke = 1'b1, all_b = 1'b0;
  logic [2:0] cmd = C_NOP;
  logic [1:0] bank = 2'd0;
  logic int_en, susp, pd_sb, pd_act, busy, wdir, adv, wcap;
  logic [2:0] cmd_q;
  logic [3:0] banks;
  logic [1:0] beat;

  always #2.5 clk = ~clk;

  cke_suspend_ctrl i_cke_suspend_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cmd_i(cmd), .bank_i(bank),
    .all_banks_i(all_b), .int_clk_en_o(int_en), .cmd_o(cmd_q), .suspend_o(susp),
    .pd_standby_o(pd_sb), .pd_active_o(pd_act), .bank_open_o(banks),
    .burst_busy_o(busy), .burst_write_o(wdir), .beat_o(beat),
    .burst_adv_o(adv), .wr_capture_o(wcap));

  typedef struct {
    logic       ie;
    logic [2:0] c;
    logic       sb, ac;
    logic [3:0] bk;
    logic       bz, dr;
    logic [1:0] bt;
    logic       ad, wc;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic       m_ie = 1'b1, m_busy = 1'b0, m_dir = 1'b0;
  logic [3:0] m_banks = 4'd0;
  logic [1:0] m_beat = 2'd0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one call per cycle, predicts outputs of that cycle
  task automatic step(logic k, logic [2:0] c, logic [1:0] b, logic a);
    exp_t e;
    logic acc, start;
    @(negedge clk);
    cke = k; cmd = c; bank = b; all_b = a;
    e.ie = m_ie;
    e.c  = m_ie ? c : C_NOP;
    e.sb = !m_ie && (m_banks == 0);
    e.ac = !m_ie && (m_banks != 0);
    e.bk = m_banks; e.bz = m_busy; e.dr = m_dir; e.bt = m_beat;
    e.ad = m_busy && m_ie;
    e.wc = e.ad && m_dir;
    q.push_back(e);
    acc   = m_ie;
    start = acc && (c == C_RD || c == C_WR);
    m_ie  = k;
    if (acc && c == C_ACT) m_banks[b] = 1'b1;
    if (acc && c == C_PRE) begin
      if (a) m_banks = 4'd0;
      else   m_banks[b] = 1'b0;
    end
    if (start) begin
      m_busy = 1'b1; m_dir = (c == C_WR); m_beat = 2'd0;
    end else if (e.ad) begin
      if (m_beat == 2'd3) begin m_busy = 1'b0; m_beat = 2'd0; end
      else m_beat = m_beat + 2'd1;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2 int_en",  {7'd0, int_en}, {7'd0, e.ie});
        chk("R2 suspend", {7'd0, susp},   {7'd0, !e.ie});
        chk("R3 R10 cmd", {5'd0, cmd_q},  {5'd0, e.c});
        chk("R4 banks",   {4'd0, banks},  {4'd0, e.bk});
        chk("R5 standby", {7'd0, pd_sb},  {7'd0, e.sb});
        chk("R6 active",  {7'd0, pd_act}, {7'd0, e.ac});
        chk("R7 busy",    {7'd0, busy},   {7'd0, e.bz});
        chk("R7 beat",    {6'd0, beat},   {6'd0, e.bt});
        if (e.bz) chk("R7 dir", {7'd0, wdir}, {7'd0, e.dr});
        chk("R8 adv",     {7'd0, adv},    {7'd0, e.ad});
        chk("R9 wcap",    {7'd0, wcap},   {7'd0, e.wc});
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 int_en", {7'd0, int_en}, 8'd1);
    chk("R1 banks",  {4'd0, banks},  8'd0);
    chk("R1 busy",   {7'd0, busy},   8'd0);
    chk("R1 adv",    {7'd0, adv},    8'd0);
    chk("R1 susp",   {7'd0, susp},   8'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 beat after release", {6'd0, beat}, 8'd0);
    chk("R1 int_en after release", {7'd0, int_en}, 8'd1);

    // standby power-down: no bank open
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b0, C_ACT, 2'd2, 1'b0);   // R3 ignored
    step(1'b1, C_NOP, 2'd0, 1'b0);
    step(1'b1, C_NOP, 2'd0, 1'b0);
    // open bank 1, plain read burst
    step(1'b1, C_ACT, 2'd1, 1'b0);
    step(1'b1, C_RD,  2'd1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, C_NOP, 2'd0, 1'b0);
    // read burst frozen by suspension (R8)
    step(1'b1, C_RD,  2'd1, 1'b0);
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b1, C_RD,  2'd1, 1'b0);   // suspended, dropped
    for (int i = 0; i < 5; i++) step(1'b1, C_NOP, 2'd0, 1'b0);
    // active power-down, commands ignored (R3, R6)
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b0, C_PRE, 2'd1, 1'b1);
    step(1'b1, C_ACT, 2'd3, 1'b0);
    // R10: first re-enabled cycle takes ACT bank 3
    step(1'b1, C_ACT, 2'd3, 1'b0);
    // write burst with suspension (R9)
    step(1'b1, C_WR,  2'd3, 1'b0);
    step(1'b1, C_NOP, 2'd0, 1'b0);
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b1, C_WR,  2'd0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, C_NOP, 2'd0, 1'b0);
    // restart while busy
    step(1'b1, C_RD,  2'd3, 1'b0);
    step(1'b1, C_NOP, 2'd0, 1'b0);
    step(1'b1, C_WR,  2'd3, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, C_NOP, 2'd0, 1'b0);
    // single precharge, then precharge all, then standby (R4, R5)
    step(1'b1, C_PRE, 2'd3, 1'b0);
    step(1'b1, C_ACT, 2'd0, 1'b0);
    step(1'b1, C_PRE, 2'd2, 1'b1);
    step(1'b0, C_NOP, 2'd0, 1'b0);
    step(1'b1, C_NOP, 2'd0, 1'b0);
    step(1'b1, 3'd6,  2'd0, 1'b0);   // unused code
    step(1'b1, C_NOP, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule